// File: doc/BRIEF.md
# Indexed Edge Detection Bank

The block watches a wide bus of monitored signals. Each bit has its own edge detector. Every cycle it reports a vector with one event bit per monitored bit. Software sets up each detector through a small indexed register port. It first writes the number of the detector it wants to change. It then writes either an edge kind or a mask bit, and that write lands on the detector it just selected. A detector can be set to fire on rising edges, falling edges, or both. A masked detector stays silent.

Edges are found by comparing each input bit with a registered copy taken in the previous cycle. The event vector is a combinational function of the live input, that registered copy and the stored configuration. A read port exposes the whole configuration as 32-bit words: the edge kinds are packed two bits per detector, and the masks one bit per detector. This lets software audit the setup without stepping through the index.

Top module: `edge_bank_top`

## Requirements
- R1: A write with `cfg_sel` = 0 loads `cfg_wdata` (0 to 255) into the detector index. Later kind and mask writes apply to the detector selected by the most recent index write.
- R2: A write with `cfg_sel` = 1 stores `cfg_wdata[1:0]` as the edge kind of the indexed detector. The encodings are 0 = rising, 1 = falling, 2 = both edges.
- R3: A kind write whose value `cfg_wdata[1:0]` is 3 is ignored, and the stored kind of the indexed detector keeps its old value.
- R4: A write with `cfg_sel` = 2 stores `cfg_wdata[0]` as the mask of the indexed detector. A masked detector (mask = 1) always drives 0 on its `evt_out` bit.
- R5: An unmasked detector of kind 0 raises its `evt_out` bit in a cycle where its input is 1 and was 0 in the previous cycle.
- R6: An unmasked detector of kind 1 raises its `evt_out` bit in a cycle where its input is 0 and was 1 in the previous cycle.
- R7: An unmasked detector of kind 2 raises its `evt_out` bit on any change of its input from the previous cycle. No detector fires when its input is unchanged.
- R8: In the first cycle after reset is released, `evt_out` is all zeros whatever the input.
- R9: For `rd_addr` 0 to 15, `rd_data` returns kind word `rd_addr`. Detector n appears in word n/16 at bits 2*(n%16)+1 : 2*(n%16).
- R10: For `rd_addr` 16 to 23, `rd_data` returns mask word `rd_addr`-16, with detector n at word n/32, bit n%32. Addresses 24 to 31 read as zero.
- R11: After reset, every kind is 0 (rising), every mask is 0, the index is 0 and `evt_out` is 0.
- R12: A write with `cfg_sel` = 3 changes no configuration state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 index, 1 edge kind, 2 mask, 3 none |
| cfg_wdata | input | 8 | Write data |
| rd_addr | input | 5 | Readback word address |
| rd_data | output | 32 | Readback word |
| mon_in | input | 256 | Monitored input bus |
| evt_out | output | 256 | Per-bit edge events |

## Verification
The bench programs all 256 detectors with a spread of kinds and masks, writes the reserved kind value 3 over some of them, and issues a write with select code 3. It then reads back every address. A design that lets the value 3 through, or that drops or misplaces a packed field, shows a wrong word here. It runs structured and pseudo-random input vectors against a bench model. This exposes swapped rising and falling logic, a toggle mode that misses one direction, and masks applied to the wrong bit. It also releases reset with the input held high. A design without first-cycle gating would report a spurious rising event on every bit.

// File: rtl/edge_bank_pkg.sv
package edge_bank_pkg;

    localparam int unsigned DEF_NUM_DET = 256;
    localparam int unsigned DEF_WORD_W  = 32;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_BOTH = 2'd2,
        EDGE_RSVD = 2'd3
    } edge_kind_e;

    typedef enum logic [1:0] {
        SEL_INDEX = 2'd0,
        SEL_KIND  = 2'd1,
        SEL_MASK  = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;

    function automatic logic edge_hit(input edge_kind_e kind, input logic prev, input logic cur);
        logic rise;
        logic fall;
        rise = ~prev & cur;
        fall = prev & ~cur;
        case (kind)
            EDGE_RISE: edge_hit = rise;
            EDGE_FALL: edge_hit = fall;
            EDGE_BOTH: edge_hit = rise | fall;
            default:   edge_hit = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/edge_cfg_regs.sv
module edge_cfg_regs
    import edge_bank_pkg::*;
#(
    parameter int unsigned NUM_DET = DEF_NUM_DET,
    localparam int unsigned IDX_W  = $clog2(NUM_DET)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [1:0]             cfg_sel,
    input  logic [IDX_W-1:0]       cfg_wdata,
    output logic [IDX_W-1:0]       cur_idx,
    output logic [2*NUM_DET-1:0]   kind_flat,
    output logic [NUM_DET-1:0]     mask_vec
);

    cfg_sel_e   sel;
    edge_kind_e new_kind;

    assign sel      = cfg_sel_e'(cfg_sel);
    assign new_kind = edge_kind_e'(cfg_wdata[1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_idx   <= '0;
            kind_flat <= '0;
            mask_vec  <= '0;
        end else if (cfg_we) begin
            case (sel)
                SEL_INDEX: cur_idx <= cfg_wdata;
                SEL_KIND: begin
                    if (new_kind != EDGE_RSVD)
                        kind_flat[2*cur_idx +: 2] <= new_kind;
                end
                SEL_MASK:  mask_vec[cur_idx] <= cfg_wdata[0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/edge_detect_bank.sv
module edge_detect_bank
    import edge_bank_pkg::*;
#(
    parameter int unsigned NUM_DET = DEF_NUM_DET
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_DET-1:0]   mon_in,
    input  logic [2*NUM_DET-1:0] kind_flat,
    input  logic [NUM_DET-1:0]   mask_vec,
    output logic [NUM_DET-1:0]   evt_out
);

    logic [NUM_DET-1:0] mon_q;
    logic               primed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mon_q    <= '0;
            primed_q <= 1'b0;
        end else begin
            mon_q    <= mon_in;
            primed_q <= 1'b1;
        end
    end

    for (genvar n = 0; n < NUM_DET; n++) begin : g_det
        edge_kind_e kind;
        assign kind       = edge_kind_e'(kind_flat[2*n +: 2]);
        assign evt_out[n] = primed_q & ~mask_vec[n] & edge_hit(kind, mon_q[n], mon_in[n]);
    end

endmodule

// File: rtl/edge_readback.sv
module edge_readback
    import edge_bank_pkg::*;
#(
    parameter int unsigned NUM_DET  = DEF_NUM_DET,
    parameter int unsigned WORD_W   = DEF_WORD_W,
    localparam int unsigned KIND_WORDS = (2*NUM_DET)/WORD_W,
    localparam int unsigned MASK_WORDS = NUM_DET/WORD_W,
    localparam int unsigned RD_AW      = $clog2(KIND_WORDS + MASK_WORDS),
    localparam int unsigned RD_DEPTH   = 1 << RD_AW
) (
    input  logic [2*NUM_DET-1:0] kind_flat,
    input  logic [NUM_DET-1:0]   mask_vec,
    input  logic [RD_AW-1:0]     rd_addr,
    output logic [WORD_W-1:0]    rd_data
);

    logic [WORD_W-1:0] words [RD_DEPTH];

    for (genvar w = 0; w < RD_DEPTH; w++) begin : g_word
        if (w < KIND_WORDS) begin : g_kind
            assign words[w] = kind_flat[w*WORD_W +: WORD_W];
        end else if (w < KIND_WORDS + MASK_WORDS) begin : g_mask
            assign words[w] = mask_vec[(w-KIND_WORDS)*WORD_W +: WORD_W];
        end else begin : g_zero
            assign words[w] = '0;
        end
    end

    assign rd_data = words[rd_addr];

endmodule

// File: rtl/edge_bank_top.sv
module edge_bank_top
    import edge_bank_pkg::*;
#(
    parameter int unsigned NUM_DET = DEF_NUM_DET,
    parameter int unsigned WORD_W  = DEF_WORD_W,
    localparam int unsigned IDX_W  = $clog2(NUM_DET),
    localparam int unsigned RD_AW  = $clog2((3*NUM_DET)/WORD_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_sel,
    input  logic [IDX_W-1:0]    cfg_wdata,
    input  logic [RD_AW-1:0]    rd_addr,
    output logic [WORD_W-1:0]   rd_data,
    input  logic [NUM_DET-1:0]  mon_in,
    output logic [NUM_DET-1:0]  evt_out
);

    logic [IDX_W-1:0]     cur_idx;
    logic [2*NUM_DET-1:0] kind_flat;
    logic [NUM_DET-1:0]   mask_vec;

    edge_cfg_regs #(.NUM_DET(NUM_DET)) cfg_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cur_idx   (cur_idx),
        .kind_flat (kind_flat),
        .mask_vec  (mask_vec)
    );

    edge_detect_bank #(.NUM_DET(NUM_DET)) det_i (
        .clk       (clk),
        .rst       (rst),
        .mon_in    (mon_in),
        .kind_flat (kind_flat),
        .mask_vec  (mask_vec),
        .evt_out   (evt_out)
    );

    edge_readback #(.NUM_DET(NUM_DET), .WORD_W(WORD_W)) rb_i (
        .kind_flat (kind_flat),
        .mask_vec  (mask_vec),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/edge_bank_chk.sv
module edge_bank_chk #(
    parameter int unsigned NUM_DET = 256,
    parameter int unsigned IDX_W   = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_we,
    input logic [1:0]           cfg_sel,
    input logic [IDX_W-1:0]     cfg_wdata,
    input logic [NUM_DET-1:0]   mon_in,
    input logic [NUM_DET-1:0]   evt_out,
    input logic [IDX_W-1:0]     cur_idx,
    input logic [2*NUM_DET-1:0] kind_flat,
    input logic [NUM_DET-1:0]   mask_vec
);

    logic seen;

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == 2'd0) |=> (cur_idx == $past(cfg_wdata))); // R1

    AST_KIND_STORE: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == 2'd1 && cfg_wdata[1:0] != 2'd3)
        |=> (kind_flat[2*$past(cur_idx) +: 2] == $past(cfg_wdata[1:0]))); // R2

    AST_KIND_RSVD_HELD: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == 2'd1 && cfg_wdata[1:0] == 2'd3) |=> $stable(kind_flat)); // R3

    AST_MASK_STORE: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == 2'd2) |=> (mask_vec[$past(cur_idx)] == $past(cfg_wdata[0]))); // R4

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
        ((evt_out & mask_vec) == '0)); // R4

    AST_EVT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (rst)
        seen |-> ((evt_out & ~(mon_in ^ $past(mon_in))) == '0)); // R7

    AST_FIRST_CYCLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !seen |-> (evt_out == '0)); // R8

    AST_SEL_NONE_HELD: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == 2'd3)
        |=> ($stable(kind_flat) && $stable(mask_vec) && $stable(cur_idx))); // R12

endmodule

bind edge_bank_top edge_bank_chk #(.NUM_DET(NUM_DET), .IDX_W(IDX_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .mon_in    (mon_in),
    .evt_out   (evt_out),
    .cur_idx   (cur_idx),
    .kind_flat (kind_flat),
    .mask_vec  (mask_vec)
);

// File: tb/edge_bank_top_tb_top.sv
module edge_bank_top_tb_top;

    localparam int NDET = 256;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_we = 1'b0;
    logic [1:0]      cfg_sel = 2'd0;
    logic [7:0]      cfg_wdata = 8'd0;
    logic [4:0]      rd_addr = 5'd0;
    logic [31:0]     rd_data;
    logic [NDET-1:0] mon_in = '0;
    logic [NDET-1:0] evt_out;

    int checks = 0;
    int failures = 0;
    int mkind [NDET];
    bit mmask [NDET];
    logic [NDET-1:0] prev_v = '0;
    logic [31:0] lcg = 32'h1234_5678;

    always #5 clk = ~clk;

    edge_bank_top dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data), .mon_in(mon_in), .evt_out(evt_out)
    );

    task automatic check_vec(input string tag, input logic [NDET-1:0] act, input logic [NDET-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_word(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        if (sel == 2'd1 && data[1:0] != 2'd3) mkind[0] = mkind[0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] exp_word(input int a);
        logic [31:0] w;
        w = '0;
        if (a < 16) begin
            for (int j = 0; j < 16; j++) w[2*j +: 2] = mkind[16*a + j][1:0];
        end else if (a < 24) begin
            for (int j = 0; j < 32; j++) w[j] = mmask[32*(a-16) + j];
        end
        return w;
    endfunction

    function automatic logic [NDET-1:0] exp_evt(input logic [NDET-1:0] p, input logic [NDET-1:0] c);
        logic [NDET-1:0] e;
        for (int i = 0; i < NDET; i++) begin
            logic r, f;
            r = ~p[i] & c[i];
            f = p[i] & ~c[i];
            case (mkind[i])
                0: e[i] = r;
                1: e[i] = f;
                2: e[i] = r | f;
                default: e[i] = 1'b0;
            endcase
            if (mmask[i]) e[i] = 1'b0;
        end
        return e;
    endfunction

    task automatic read_all(input string tag);
        for (int a = 0; a < 32; a++) begin
            @(negedge clk);
            rd_addr = a[4:0];
            #1;
            check_word(tag, rd_data, exp_word(a));
        end
    endtask

    task automatic drive_check(input logic [NDET-1:0] v);
        @(negedge clk);
        mon_in = v;
        #1;
        check_vec("R5 R6 R7 R4 event vector", evt_out, exp_evt(prev_v, v));
        prev_v = v;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NDET; i++) begin mkind[i] = 0; mmask[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check_vec("R11 evt after reset", evt_out, '0);
        read_all("R11 R9 R10 reset readback");

        // program every detector: R1 index, R2 kind, R4 mask, R3 reserved kind
        for (int n = 0; n < NDET; n++) begin
            cfg_write(2'd0, n[7:0]);
            cfg_write(2'd1, 8'(n % 3));
            mkind[n] = n % 3;
            cfg_write(2'd2, {7'd0, (n % 7 == 5)});
            mmask[n] = (n % 7 == 5);
            if (n % 11 == 0) cfg_write(2'd1, 8'hFF);
        end
        // R12: reserved select leaves all state unchanged
        cfg_write(2'd3, 8'h5A);
        cfg_write(2'd1, 8'h02);
        mkind[255] = 2;
        read_all("R9 R10 R3 R12 R1 readback");

        // event sweeps
        drive_check('0);
        drive_check('1);
        drive_check('0);
        drive_check({(NDET/4){4'h5}});
        drive_check({(NDET/4){4'hA}});
        drive_check({(NDET/4){4'hA}});
        for (int k = 0; k < 40; k++) begin
            logic [NDET-1:0] v;
            for (int w = 0; w < NDET/32; w++) begin
                lcg = lcg * 32'd1103515245 + 32'd12345;
                v[32*w +: 32] = lcg ^ (lcg >> 13);
            end
            drive_check(v);
        end

        // R8: release reset with input high; no event in the first cycle
        @(negedge clk);
        rst = 1'b1;
        mon_in = '1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        check_vec("R8 first cycle after reset", evt_out, '0);
        for (int i = 0; i < NDET; i++) begin mkind[i] = 0; mmask[i] = 1'b0; end
        prev_v = '1;
        drive_check('1);
        drive_check('0);
        drive_check('1);
        check_vec("R11 R5 all rising after reset", evt_out, '1);
        read_all("R11 readback after second reset");

        finish_run();
    end

endmodule